// File: doc/BRIEF.md
# Predicate Indirection Table

This block turns a small set of predication configuration entries into the per-operand predicate mask that an issue stage needs. Sixteen entries are written through a simple register-style write port. Each entry names an operand register (integer or floating-point) and the integer register that holds that operand's predicate bits. It also carries an invert flag and a zeroing flag.

After any entry is written, a sequencer rebuilds two 32-slot tables, one for integer operands and one for floating-point operands. It clears every slot first. It then applies the entries one per cycle in ascending order, so a later entry overrides an earlier one that has the same key. While the rebuild runs, `busy` is high and the consumer must hold back lookups.

A lookup takes an operand register number and a class selector. Within the same cycle it drives the integer register file read address from the matching slot and returns the predicate mask, inverted when the slot asks for it, together with the slot's zeroing flag. An operand with no matching slot gets an all-ones mask, so every element is active.

Top module: `pred_map_unit`

## Requirements
- R1: After reset, `busy` is low and every lookup misses: `lk_hit`=0, `lk_mask` all ones, `lk_zero`=0.
- R2: A write with `cfg_we`=1 stores entry `cfg_idx` with fields `cfg_used` (entry takes part), `cfg_is_fp` (0 = integer key, 1 = floating-point key), `cfg_key` (operand register), `cfg_src` (integer register holding the mask), `cfg_inv` and `cfg_zero`.
- R3: The edge that takes a write raises `busy`. `busy` then stays high for exactly NUM_CFG cycles, after which lookups reflect the complete new configuration.
- R4: A write that arrives while a rebuild is running restarts the rebuild. `busy` stays high for NUM_CFG cycles counted from the last write.
- R5: On a hit, `rf_addr` equals the slot's source register, and `lk_mask` equals `rf_rdata` when the invert flag is 0.
- R6: On a hit with the invert flag set, `lk_mask` is the bitwise complement of `rf_rdata`.
- R7: On a miss, `lk_hit`=0, `lk_mask` is all ones and `lk_zero`=0, whatever `rf_rdata` holds.
- R8: Integer and floating-point keys live in separate tables, so the same register number may map differently for each class. Floating-point lookups still read their mask through the integer read port `rf_addr`.
- R9: When several used entries share a class and key, the entry with the highest index decides the lookup.
- R10: On a hit, `lk_zero` equals the slot's zeroing flag.
- R11: An entry written with `cfg_used`=0 contributes nothing. Lookups for its key fall back to a lower-indexed entry with that key, or miss when no such entry exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NUM_CFG) | Entry index written |
| cfg_used | input | 1 | Entry takes part in the table |
| cfg_is_fp | input | 1 | Key class: 0 integer, 1 floating-point |
| cfg_key | input | 5 | Operand register number being predicated |
| cfg_src | input | 5 | Integer register holding the predicate |
| cfg_inv | input | 1 | Invert the predicate bits |
| cfg_zero | input | 1 | Zero masked-off elements |
| busy | output | 1 | Table rebuild in progress; lookups must wait |
| lk_is_fp | input | 1 | Lookup class: 0 integer, 1 floating-point |
| lk_reg | input | 5 | Operand register number looked up |
| lk_hit | output | 1 | A slot matched the lookup |
| lk_mask | output | XLEN | Effective predicate mask |
| lk_zero | output | 1 | Zeroing flag of the matched slot |
| rf_addr | output | 5 | Integer register file read address |
| rf_rdata | input | XLEN | Integer register file read data |

## Verification
A configuration write takes effect on `busy` at the clock edge that takes it. The bench therefore drives writes half a period before an edge and samples `busy` at each following falling edge, expecting exactly NUM_CFG high samples. Lookups are combinational through the read port, so the bench changes `lk_is_fp`/`lk_reg` at a falling edge and compares `lk_hit`, `lk_mask`, `lk_zero` and `rf_addr` one time unit later. It does this only once `busy` has dropped. Expected results come from a bench model that walks the entries in index order against a bench-held register file with random contents.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  typedef struct packed {
    logic              used;
    logic              is_fp;
    logic [REG_AW-1:0] key;
    logic [REG_AW-1:0] src;
    logic              inv;
    logic              zero;
  } cfg_entry_t;

  typedef struct packed {
    logic              en;
    logic [REG_AW-1:0] src;
    logic              inv;
    logic              zero;
  } slot_t;
endpackage

// File: rtl/pmu_cfg_store.sv
module pmu_cfg_store
  import pmu_pkg::*;
#(
  parameter int NUM_CFG = 16,
  localparam int IW = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  cfg_entry_t       wdata,
  input  logic [IW-1:0]    ridx,
  output cfg_entry_t       rdata
);
  cfg_entry_t mem [NUM_CFG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CFG; k++) mem[k] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/pmu_rebuild_seq.sv
module pmu_rebuild_seq #(
  parameter int NUM_CFG = 16,
  localparam int IW = $clog2(NUM_CFG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          clear,
  output logic          apply,
  output logic [IW-1:0] step
);
  localparam logic [IW-1:0] LAST = IW'(NUM_CFG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == LAST) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign clear = start;
  assign apply = busy & ~start;
endmodule

// File: rtl/pmu_expand_table.sv
module pmu_expand_table
  import pmu_pkg::*;
#(
  localparam int SLOTS = 2 * NREG,
  localparam int SW    = REG_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              apply,
  input  cfg_entry_t        entry,
  input  logic              lk_is_fp,
  input  logic [REG_AW-1:0] lk_reg,
  output slot_t             lk_slot
);
  slot_t tbl [SLOTS];
  logic [SW-1:0] widx;
  logic [SW-1:0] ridx;

  assign widx = {entry.is_fp, entry.key};
  assign ridx = {lk_is_fp, lk_reg};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int k = 0; k < SLOTS; k++) tbl[k] <= '0;
    end else if (apply && entry.used) begin
      tbl[widx].en   <= 1'b1;
      tbl[widx].src  <= entry.src;
      tbl[widx].inv  <= entry.inv;
      tbl[widx].zero <= entry.zero;
    end
  end

  assign lk_slot = tbl[ridx];
endmodule

// File: rtl/pred_map_unit.sv
module pred_map_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CFG = 16,
  parameter int XLEN    = 32,
  localparam int IW     = $clog2(NUM_CFG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic              cfg_used,
  input  logic              cfg_is_fp,
  input  logic [REG_AW-1:0] cfg_key,
  input  logic [REG_AW-1:0] cfg_src,
  input  logic              cfg_inv,
  input  logic              cfg_zero,
  output logic              busy,
  input  logic              lk_is_fp,
  input  logic [REG_AW-1:0] lk_reg,
  output logic              lk_hit,
  output logic [XLEN-1:0]   lk_mask,
  output logic              lk_zero,
  output logic [REG_AW-1:0] rf_addr,
  input  logic [XLEN-1:0]   rf_rdata
);
  cfg_entry_t wentry, rentry;
  slot_t      slot;
  logic       clear, apply;
  logic [IW-1:0] step;

  assign wentry = '{used: cfg_used, is_fp: cfg_is_fp, key: cfg_key,
                    src: cfg_src, inv: cfg_inv, zero: cfg_zero};

  pmu_cfg_store #(.NUM_CFG(NUM_CFG)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_idx), .wdata(wentry),
    .ridx(step), .rdata(rentry)
  );

  pmu_rebuild_seq #(.NUM_CFG(NUM_CFG)) u_seq (
    .clk(clk), .rst(rst), .start(cfg_we), .busy(busy),
    .clear(clear), .apply(apply), .step(step)
  );

  pmu_expand_table u_tbl (
    .clk(clk), .rst(rst), .clear(clear), .apply(apply), .entry(rentry),
    .lk_is_fp(lk_is_fp), .lk_reg(lk_reg), .lk_slot(slot)
  );

  assign rf_addr = slot.src;
  assign lk_hit  = slot.en;
  assign lk_zero = slot.en & slot.zero;

  always_comb begin
    if (!slot.en)      lk_mask = '1;
    else if (slot.inv) lk_mask = ~rf_rdata;
    else               lk_mask = rf_rdata;
  end
endmodule

// File: rtl/pred_map_unit_checks.sv
module pred_map_unit_checks #(
  parameter int NUM_CFG = 16,
  parameter int XLEN    = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic            busy,
  input logic            lk_hit,
  input logic [XLEN-1:0] lk_mask,
  input logic            lk_zero,
  input logic [XLEN-1:0] rf_rdata
);
  localparam int CW = $clog2(NUM_CFG + 1) + 1;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || cfg_we) run <= '0;
    else if (busy)     run <= run + 1'b1;
  end

  AST_WRITE_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> busy); // R3

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_we) |-> (run < CW'(NUM_CFG))); // R4

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_we && run == CW'(NUM_CFG - 1)) |=> !busy); // R3

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_mask == '1 && !lk_zero)); // R7

  AST_HIT_FROM_RF: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_mask == rf_rdata || lk_mask == ~rf_rdata)); // R5
endmodule

bind pred_map_unit pred_map_unit_checks #(.NUM_CFG(NUM_CFG), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .busy(busy), .lk_hit(lk_hit),
  .lk_mask(lk_mask), .lk_zero(lk_zero), .rf_rdata(rf_rdata)
);

// File: tb/sim_pred_map_unit.sv
module sim_pred_map_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CFG = 16;
  localparam int XLEN = 32;
  localparam int IW = $clog2(NUM_CFG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic cfg_used = 1'b0, cfg_is_fp = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0;
  logic [4:0] cfg_key = '0, cfg_src = '0;
  logic busy;
  logic lk_is_fp = 1'b0;
  logic [4:0] lk_reg = '0;
  logic lk_hit, lk_zero;
  logic [XLEN-1:0] lk_mask;
  logic [4:0] rf_addr;
  logic [XLEN-1:0] rf_rdata;

  logic [XLEN-1:0] rf [32];
  assign rf_rdata = rf[rf_addr];

  bit m_used [NUM_CFG];
  bit m_fp [NUM_CFG];
  bit [4:0] m_key [NUM_CFG];
  bit [4:0] m_src [NUM_CFG];
  bit m_inv [NUM_CFG];
  bit m_zero [NUM_CFG];

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_map_unit #(.NUM_CFG(NUM_CFG), .XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_used(cfg_used), .cfg_is_fp(cfg_is_fp), .cfg_key(cfg_key),
    .cfg_src(cfg_src), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero), .busy(busy),
    .lk_is_fp(lk_is_fp), .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_mask(lk_mask),
    .lk_zero(lk_zero), .rf_addr(rf_addr), .rf_rdata(rf_rdata)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int idx, input bit used, input bit fp, input bit [4:0] key,
                           input bit [4:0] src, input bit inv, input bit zero);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_used = used; cfg_is_fp = fp;
    cfg_key = key; cfg_src = src; cfg_inv = inv; cfg_zero = zero;
    m_used[idx] = used; m_fp[idx] = fp; m_key[idx] = key;
    m_src[idx] = src; m_inv[idx] = inv; m_zero[idx] = zero;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R3: count busy samples after a write
  task automatic wait_idle(input string req);
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, XLEN'(n), XLEN'(NUM_CFG));
  endtask

  function automatic void model(input bit fp, input bit [4:0] r, output bit hit,
                                output bit [4:0] src, output bit [XLEN-1:0] mask,
                                output bit zero);
    bit inv = 1'b0;
    hit = 1'b0; src = '0; zero = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (m_used[i] && m_fp[i] == fp && m_key[i] == r) begin
        hit = 1'b1; src = m_src[i]; inv = m_inv[i]; zero = m_zero[i];
      end
    end
    if (!hit)     mask = '1;
    else if (inv) mask = ~rf[src];
    else          mask = rf[src];
  endfunction

  task automatic lookup(input string req, input bit fp, input bit [4:0] r);
    bit hit, zero;
    bit [4:0] src;
    bit [XLEN-1:0] mask;
    @(negedge clk);
    lk_is_fp = fp; lk_reg = r;
    #1;
    model(fp, r, hit, src, mask, zero);
    check({req, " hit"}, XLEN'(lk_hit), XLEN'(hit));
    check({req, " mask"}, lk_mask, mask);
    check({req, " zero"}, XLEN'(lk_zero), XLEN'(zero));
    if (hit) check({req, " rf_addr"}, XLEN'(rf_addr), XLEN'(src));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed1);
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    for (int i = 0; i < NUM_CFG; i++) begin
      m_used[i] = 0; m_fp[i] = 0; m_key[i] = 0; m_src[i] = 0; m_inv[i] = 0; m_zero[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", XLEN'(busy), '0);
    lookup("R1", 1'b0, 5'd0);
    lookup("R1", 1'b1, 5'd31);

    // R2 R5 R10: integer key 3 -> src 7, zeroing
    write_cfg(0, 1, 0, 5'd3, 5'd7, 0, 1);
    wait_idle("R3 busy span");
    lookup("R5 R10 R2", 1'b0, 5'd3);
    // R8 R6: fp key 3 -> src 9 inverted
    write_cfg(1, 1, 1, 5'd3, 5'd9, 1, 0);
    wait_idle("R3 busy span");
    lookup("R6 R8", 1'b1, 5'd3);
    lookup("R8 int unchanged", 1'b0, 5'd3);
    // R7 miss with other rf content
    lookup("R7", 1'b0, 5'd4);
    // R9: higher index wins
    write_cfg(5, 1, 0, 5'd3, 5'd12, 1, 0);
    wait_idle("R3 busy span");
    lookup("R9", 1'b0, 5'd3);
    check("R9 rf_addr", XLEN'(rf_addr), XLEN'(12));
    // R11: unused entry falls back
    write_cfg(5, 0, 0, 5'd3, 5'd12, 1, 0);
    wait_idle("R3 busy span");
    lookup("R11 fallback", 1'b0, 5'd3);
    write_cfg(0, 0, 0, 5'd3, 5'd7, 0, 1);
    wait_idle("R3 busy span");
    lookup("R11 miss", 1'b0, 5'd3);
    // R4: restart during rebuild
    write_cfg(2, 1, 0, 5'd20, 5'd1, 0, 0);
    repeat (4) @(negedge clk);
    check("R4 busy mid", XLEN'(busy), 32'd1);
    write_cfg(3, 1, 0, 5'd20, 5'd2, 0, 1);
    wait_idle("R4 restart span");
    lookup("R4 R9 result", 1'b0, 5'd20);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      write_cfg($urandom_range(NUM_CFG-1), $urandom_range(3) != 0, $urandom_range(1),
                5'($urandom_range(7)), 5'($urandom), $urandom_range(1), $urandom_range(1));
      wait_idle("R3 busy span");
      for (int i = 0; i < 32; i++) rf[i] = $urandom;
      for (int k = 0; k < 12; k++)
        lookup("R5 R6 R7 R8 R9 rand", 1'($urandom_range(1)), 5'($urandom_range(9)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule